// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a processor's virtual address into a physical word address through a page table with one level. The table sits in the same word-addressed memory as the data. The walker takes one processor request at a time. It splits the address into a page number and a 12-bit offset, then reads the table entry at the base register plus the page number. If the entry is mapped, it forms the physical address from the entry's frame field and the offset, and it performs the requested read or write on the same memory port.

Each entry carries three flags. Bit 31 marks the page as mapped. Bit 30 records that the page has been written. Bit 29 records that the page has been used. The walker keeps the used and written flags current so that a write-back replacement scheme can rely on them. When a flag must change, the walker writes the entry back once, between the entry read and the data access. An unmapped page ends the request with a one-cycle fault pulse instead of a data access. The base register can be reloaded at any time, so that each process can have its own table.

The controller is a state machine with seven states:
- `S_IDLE`: ready for a request.
- `S_PTE_RD`: entry read in progress.
- `S_PTE_CHK`: entry inspection.
- `S_PTE_WB`: entry flag write-back.
- `S_DATA`: data access.
- `S_RESP`: one-cycle response.
- `S_FAULT`: one-cycle fault pulse.

Its transitions are:
- `S_IDLE`→`S_PTE_RD` on an accepted request.
- `S_PTE_RD`→`S_PTE_CHK` on memory acknowledge.
- `S_PTE_CHK`→`S_FAULT` for an unmapped entry.
- `S_PTE_CHK`→`S_PTE_WB` when a flag must be set.
- `S_PTE_CHK`→`S_DATA` otherwise.
- `S_PTE_WB`→`S_DATA` on acknowledge.
- `S_DATA`→`S_RESP` on acknowledge.
- `S_RESP`→`S_IDLE` and `S_FAULT`→`S_IDLE`, both unconditional.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req`, `rsp_valid` and `fault` are 0.
- R2: The page number is `req_vaddr[31:12]` and the offset is `req_vaddr[11:0]`. The first memory access of every request is a read at word address base + page number.
- R3: For a mapped entry, the data access goes to {entry[19:0], offset}. For a read, `rsp_valid` is high for one cycle with `rsp_rdata` equal to the word read there.
- R4: When no flag needs changing (bit 29 already set on a read; bits 29 and 30 both set on a write), a request makes exactly two memory accesses: the entry read, then the data access.
- R5: If bit 29 is clear, or the request is a write and bit 30 is clear, exactly one write of the entry goes to the same entry address between the entry read and the data access. That write sets bit 29, sets bit 30 for writes, and leaves all other bits unchanged.
- R6: An entry with bit 31 clear causes no further memory access and no `rsp_valid`. Instead `fault` is high for exactly one cycle, and `fault_vpn` holds the faulting page number from then until the next fault.
- R7: A write request writes `req_wdata` to the physical address and completes with a one-cycle `rsp_valid`.
- R8: Only one request is in flight. `req_ready` stays 0 from acceptance until the response or fault cycle, and a request presented meanwhile starts no memory access.
- R9: A base register write is used by requests accepted after it. A write during a walk does not move that walk's entry accesses.
- R10: Once `mem_req` is raised, it stays high with a stable address, write enable and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Walker can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_rdata | output | 32 | Read data |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory access done |
| fault | output | 1 | One-cycle page fault pulse |
| fault_vpn | output | 20 | Page number of the last fault |

## Verification
The embedded properties check the following on every cycle:
- The memory request holds steady until it is acknowledged.
- The walker never looks ready while it drives memory.
- A fault is a single-cycle pulse that never coincides with a response.
- The latched fault page stays put after the pulse.

The directed scenarios are the only way to show the rest. That covers the translated address value, the number and order of memory accesses, the exact flag bits written back to the entry, per-process base switching, and the fact that a request held during a busy walk is dropped.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 32;
    localparam int PAGE_W  = 12;
    localparam int BIT_V   = 31;
    localparam int BIT_D   = 30;
    localparam int BIT_R   = 29;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTE_RD,
        S_PTE_CHK,
        S_PTE_WB,
        S_DATA,
        S_RESP,
        S_FAULT
    } walk_state_e;
endpackage

// File: rtl/pt_addr_map.sv
module pt_addr_map #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    localparam int VPN_W = ADDR_W - PAGE_W
) (
    input  logic [ADDR_W-1:0] new_vaddr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] held_vaddr,
    input  logic [VPN_W-1:0]  frame,
    output logic [VPN_W-1:0]  held_vpn,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [VPN_W-1:0]  new_vpn;
    logic [PAGE_W-1:0] held_off;

    always_comb begin
        new_vpn    = new_vaddr[ADDR_W-1:PAGE_W];
        held_vpn   = held_vaddr[ADDR_W-1:PAGE_W];
        held_off   = held_vaddr[PAGE_W-1:0];
        entry_addr = base + {{PAGE_W{1'b0}}, new_vpn};
        phys_addr  = {frame, held_off};
    end
endmodule

// File: rtl/pt_entry_ctl.sv
module pt_entry_ctl #(
    parameter int WORD_W  = 32,
    parameter int FRAME_W = 20,
    parameter int BIT_V   = 31,
    parameter int BIT_D   = 30,
    parameter int BIT_R   = 29
) (
    input  logic [WORD_W-1:0]  entry,
    input  logic               is_write,
    output logic               mapped,
    output logic               need_update,
    output logic [WORD_W-1:0]  entry_new,
    output logic [FRAME_W-1:0] frame
);
    always_comb begin
        mapped       = entry[BIT_V];
        frame        = entry[FRAME_W-1:0];
        entry_new    = entry;
        entry_new[BIT_R] = 1'b1;
        if (is_write) entry_new[BIT_D] = 1'b1;
        need_update  = !entry[BIT_R] || (is_write && !entry[BIT_D]);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int WORD_W = pt_walker_pkg::WORD_W,
    parameter int ADDR_W = pt_walker_pkg::ADDR_W,
    parameter int PAGE_W = pt_walker_pkg::PAGE_W,
    localparam int VPN_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              fault,
    output logic [VPN_W-1:0]  fault_vpn
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic              write_q;
    logic [WORD_W-1:0] wdata_q;
    logic [ADDR_W-1:0] entry_addr_q;
    logic [WORD_W-1:0] entry_q;
    logic [WORD_W-1:0] rdata_q;
    logic [VPN_W-1:0]  fault_vpn_q;

    logic [VPN_W-1:0]  held_vpn;
    logic [ADDR_W-1:0] entry_addr_new;
    logic [ADDR_W-1:0] phys_addr;
    logic              mapped;
    logic              need_update;
    logic [WORD_W-1:0] entry_new;
    logic [VPN_W-1:0]  frame;
    logic              accept;

    pt_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .new_vaddr  (req_vaddr),
        .base       (base_q),
        .held_vaddr (vaddr_q),
        .frame      (frame),
        .held_vpn   (held_vpn),
        .entry_addr (entry_addr_new),
        .phys_addr  (phys_addr)
    );

    pt_entry_ctl #(
        .WORD_W(WORD_W), .FRAME_W(VPN_W),
        .BIT_V(BIT_V), .BIT_D(BIT_D), .BIT_R(BIT_R)
    ) u_entry (
        .entry       (entry_q),
        .is_write    (write_q),
        .mapped      (mapped),
        .need_update (need_update),
        .entry_new   (entry_new),
        .frame       (frame)
    );

    assign accept = req_valid && (state_q == S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_PTE_RD;
            S_PTE_RD:  if (mem_ack) state_d = S_PTE_CHK;
            S_PTE_CHK: begin
                if (!mapped)          state_d = S_FAULT;
                else if (need_update) state_d = S_PTE_WB;
                else                  state_d = S_DATA;
            end
            S_PTE_WB:  if (mem_ack) state_d = S_DATA;
            S_DATA:    if (mem_ack) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q       <= '0;
            vaddr_q      <= '0;
            write_q      <= 1'b0;
            wdata_q      <= '0;
            entry_addr_q <= '0;
            entry_q      <= '0;
            rdata_q      <= '0;
            fault_vpn_q  <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (accept) begin
                vaddr_q      <= req_vaddr;
                write_q      <= req_write;
                wdata_q      <= req_wdata;
                entry_addr_q <= entry_addr_new;
            end
            if (state_q == S_PTE_RD && mem_ack) entry_q <= mem_rdata;
            if (state_q == S_DATA && mem_ack && !write_q) rdata_q <= mem_rdata;
            if (state_q == S_PTE_CHK && !mapped) fault_vpn_q <= held_vpn;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        fault     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_addr_q;
        mem_wdata = '0;
        unique case (state_q)
            S_IDLE:    req_ready = 1'b1;
            S_PTE_RD:  mem_req = 1'b1;
            S_PTE_CHK: ;
            S_PTE_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = entry_new;
            end
            S_DATA: begin
                mem_req   = 1'b1;
                mem_we    = write_q;
                mem_addr  = phys_addr;
                mem_wdata = wdata_q;
            end
            S_RESP:    rsp_valid = 1'b1;
            S_FAULT:   fault = 1'b1;
            default:   ;
        endcase
    end

    assign rsp_rdata = rdata_q;
    assign fault_vpn = fault_vpn_q;

    // R10: request held steady until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8: never ready while a memory access is outstanding
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R6: fault is a single-cycle pulse
    p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R6: faulting page number is kept after the pulse
    p_fault_vpn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> $stable(fault_vpn));

    // R6: fault never coincides with a response or memory access
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rsp_valid && !mem_req));

    // R3: response is a single-cycle pulse
    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        fault;
    logic [19:0] fault_vpn;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .fault(fault), .fault_vpn(fault_vpn)
    );

    // memory model: one-cycle acknowledge
    logic [31:0] mem [0:4095];
    function automatic int midx(input logic [31:0] a);
        return int'({a[13:12], a[9:0]});
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[midx(mem_addr)] <= mem_wdata;
                else        mem_rdata <= mem[midx(mem_addr)];
            end
        end
    end

    // access log
    logic [31:0] log_addr [0:7];
    logic [31:0] log_data [0:7];
    logic        log_we   [0:7];
    int          log_n = 0;
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (log_n < 8) begin
                log_addr[log_n] <= mem_addr;
                log_we[log_n]   <= mem_we;
                log_data[log_n] <= mem_wdata;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        got_rsp, got_fault;
    logic [31:0] got_data;

    task automatic run_req(input logic wr, input logic [31:0] va, input logic [31:0] wd);
        got_rsp = 0; got_fault = 0; got_data = '0;
        @(negedge clk);
        log_n = 0;
        req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid || fault) break;
            @(negedge clk);
        end
        got_rsp = rsp_valid; got_fault = fault; got_data = rsp_rdata;
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        check(rsp_valid == 1'b0 && fault == 1'b0, "R1 rsp/fault", 32'({rsp_valid, fault}), 32'd0);
    endtask

    task automatic t_read_mapped;
        run_req(0, 32'h0001_0020, '0);
        check(got_rsp, "R3 rsp", 32'(got_rsp), 32'd1);
        check(got_data == 32'h0000_2222, "R3 rdata", got_data, 32'h2222);
        check(log_n == 2, "R4 access count", 32'(log_n), 32'd2);
        check(log_addr[0] == 32'h110 && !log_we[0], "R2 entry addr", log_addr[0], 32'h110);
        check(log_addr[1] == 32'h22020 && !log_we[1], "R3 data addr", log_addr[1], 32'h22020);
    endtask

    task automatic t_ref_update;
        run_req(0, 32'h0001_1abc, '0);
        check(got_data == 32'h0000_4545, "R3 rdata ref", got_data, 32'h4545);
        check(log_n == 3, "R5 access count", 32'(log_n), 32'd3);
        check(log_we[1] && log_addr[1] == 32'h111, "R5 wb addr", log_addr[1], 32'h111);
        check(log_data[1] == 32'hA000_0045, "R5 wb value", log_data[1], 32'hA000_0045);
        check(log_addr[2] == 32'h45abc, "R5 data after wb", log_addr[2], 32'h45abc);
    endtask

    task automatic t_write_dirty;
        run_req(1, 32'h0001_3040, 32'hCAFE_0001);
        check(got_rsp, "R7 rsp", 32'(got_rsp), 32'd1);
        check(log_n == 3, "R5 write count", 32'(log_n), 32'd3);
        check(log_data[1] == 32'hE000_0022, "R5 dirty value", log_data[1], 32'hE000_0022);
        check(mem[midx(32'h22040)] == 32'hCAFE_0001, "R7 data written", mem[midx(32'h22040)], 32'hCAFE_0001);
        check(mem[midx(32'h113)] == 32'hE000_0022, "R5 entry stored", mem[midx(32'h113)], 32'hE000_0022);
    endtask

    task automatic t_write_clean;
        run_req(1, 32'h0001_5100, 32'h1234_5678);
        check(log_n == 2, "R4 write count", 32'(log_n), 32'd2);
        check(log_we[1] && log_addr[1] == 32'h33100, "R7 write addr", log_addr[1], 32'h33100);
        check(log_data[1] == 32'h1234_5678, "R7 write data", log_data[1], 32'h1234_5678);
    endtask

    task automatic t_fault;
        run_req(0, 32'h0001_6000, '0);
        check(got_fault && !got_rsp, "R6 fault", 32'({got_fault, got_rsp}), 32'h2);
        check(fault_vpn == 20'h16, "R6 vpn", 32'(fault_vpn), 32'h16);
        @(negedge clk);
        check(fault == 1'b0, "R6 pulse width", 32'(fault), 32'd0);
        repeat (3) @(negedge clk);
        check(log_n == 1, "R6 access count", 32'(log_n), 32'd1);
        check(fault_vpn == 20'h16, "R6 vpn held", 32'(fault_vpn), 32'h16);
    endtask

    task automatic t_busy;
        @(negedge clk);
        log_n = 0;
        req_valid = 1; req_write = 0; req_vaddr = 32'h0001_2010;
        @(negedge clk);
        req_vaddr = 32'h0001_8000;
        for (int i = 0; i < 3; i++) begin
            check(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        req_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        check(rsp_rdata == 32'h0000_1010, "R8 first served", rsp_rdata, 32'h1010);
        repeat (6) @(negedge clk);
        check(log_n == 2, "R8 no extra access", 32'(log_n), 32'd2);
    endtask

    task automatic t_base;
        @(negedge clk);
        log_n = 0;
        req_valid = 1; req_write = 0; req_vaddr = 32'h0001_4080;
        @(negedge clk);
        req_valid = 0;
        base_we = 1; base_wdata = 32'h200;
        @(negedge clk);
        base_we = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        check(log_addr[0] == 32'h114 && log_addr[1] == 32'h114, "R9 walk unmoved", log_addr[1], 32'h114);
        run_req(0, 32'h0001_0020, '0);
        check(log_addr[0] == 32'h210, "R9 new base", log_addr[0], 32'h210);
        check(got_data == 32'h0000_3333, "R9 new table data", got_data, 32'h3333);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        base_wdata = 32'h100; base_we = 1;
        mem[midx(32'h110)]   = 32'hA000_0022;
        mem[midx(32'h22020)] = 32'h0000_2222;
        mem[midx(32'h111)]   = 32'h8000_0045;
        mem[midx(32'h45abc)] = 32'h0000_4545;
        mem[midx(32'h112)]   = 32'hA000_0045;
        mem[midx(32'h45010)] = 32'h0000_1010;
        mem[midx(32'h113)]   = 32'hA000_0022;
        mem[midx(32'h114)]   = 32'h8000_0022;
        mem[midx(32'h115)]   = 32'hE000_0033;
        mem[midx(32'h116)]   = 32'h6000_0022;
        mem[midx(32'h118)]   = 32'hA000_0022;
        mem[midx(32'h210)]   = 32'hA000_0033;
        mem[midx(32'h33020)] = 32'h0000_3333;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        @(negedge clk);
        base_we = 0;
        t_read_mapped();
        t_ref_update();
        t_write_dirty();
        t_write_clean();
        t_fault();
        t_busy();
        t_base();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule